// File: doc/BRIEF.md
# Scan-Chain Register Access Slave

This block is a small register file that a host reaches over a boundary-scan port. It sits behind a test access port controller that is not part of this block. The controller tells it when its user instruction is loaded, and gives it the capture, shift and update strobes of the data-register path. Serial data enters on `tdi` and leaves on `tdo`, all clocked by the test clock `clk`. The host scans in a frame. At the update strobe the block checks the frame and decodes it as a register write or as a read request.

Eleven 32-bit job words and a clock-setting word drive the computing core as plain outputs. A write to the last job word starts a new job, one cycle later. Results come back through an external result queue. Reading the result address takes one entry from that queue, or returns all ones when the queue is empty. A frame that fails its parity check, has the wrong length or carries the wrong direction flag changes nothing.

Top module: `jrs_top`

## Requirements
- R1: After synchronous reset all eleven job words and the clock-setting word are zero, `job_start` is low and `tdo` is low.
- R2: A write frame has 38 stream bits, scanned with stream bit 0 first. Bits 0..31 carry the data, least significant first. Bits 32..35 carry the address, least significant first. Bit 36 is 1. Bit 37 makes the count of ones over all 38 bits odd. At update it stores the data: addresses 1..11 go to job word (address-1) on `job_words[32*(address-1) +: 32]`, and address 13 goes to `clk_cfg`.
- R3: A read request frame has 6 stream bits: address in bits 0..3, bit 4 equal to 0, and bit 5 making the count of ones odd. The next data scan shifts the addressed value out on `tdo`, least significant bit first. Bit k is visible during the k-th shift cycle, before its clock edge.
- R4: A frame whose total count of ones is even is discarded, whether it is a write or a read request.
- R5: A frame whose length at update is neither 6 nor 38 bits is discarded. So is a 38-bit frame with bit 36 equal to 0, and a 6-bit frame with bit 4 equal to 1.
- R6: A valid write to address 11 raises `job_start` for exactly one cycle. It is high on the second rising edge after the edge that samples the update strobe. Writes to other addresses never raise it.
- R7: A read of address 14 asserts `res_pop` for one cycle, in the capture cycle of the scan that returns the value, when `res_empty` is low. The value returned is `res_data`. When the queue is empty, the read returns 0xFFFFFFFF and `res_pop` stays low.
- R8: Addresses 0, 12 and 15 read as zero. Writes to 0, 12, 14 and 15 change no job word and do not change `clk_cfg`.
- R9: While `sel` is low, the capture, shift and update strobes have no effect.
- R10: A data scan with no pending read request shifts out zeros. A pending request serves exactly one following scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | User instruction selected |
| capture | input | 1 | Data-register capture strobe |
| shift | input | 1 | Data-register shift strobe |
| update | input | 1 | Data-register update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| res_empty | input | 1 | Result queue is empty |
| res_data | input | 32 | Head entry of the result queue |
| res_pop | output | 1 | Take the head entry from the result queue |
| job_words | output | 352 | Eleven job words, word 0 in the low bits |
| clk_cfg | output | 32 | Clock-setting word |
| job_start | output | 1 | One-cycle job start pulse |

## Verification
Valid writes with random data to random addresses are mixed with frames that have one parity bit flipped. Checking the output ports after each frame separates a correct decode from parity, address or data bit misplacement. Directed frames of 37 and 39 bits, frames with the wrong direction flag, and frames sent with `sel` low show that length, flag and select qualify the update. The result queue is loaded with three entries and read four times. This shows one pop per read, the order of the results, and the all-ones value on an empty queue. Reads of the unmapped addresses and of a request with even parity show the zero fill.

// File: rtl/jrs_pkg.sv
package jrs_pkg;
    localparam int WORD_W  = 32;
    localparam int ADDR_W  = 4;
    localparam int NUM_JOB = 11;
    localparam int WR_LEN  = WORD_W + ADDR_W + 2;
    localparam int RD_LEN  = ADDR_W + 2;
    localparam int CNT_W   = $clog2(WR_LEN + 2);

    localparam logic [ADDR_W-1:0] ADDR_LAUNCH = ADDR_W'(11);
    localparam logic [ADDR_W-1:0] ADDR_CLKCFG = ADDR_W'(13);
    localparam logic [ADDR_W-1:0] ADDR_RESULT = ADDR_W'(14);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } wr_req_t;

    function automatic logic ones_odd(input logic [WR_LEN-1:0] bits);
        return ^bits;
    endfunction
endpackage

// File: rtl/jrs_frame_rx.sv
module jrs_frame_rx
    import jrs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              capture,
    input  logic              shift,
    input  logic              update,
    input  logic              tdi,
    output logic              wr_valid,
    output wr_req_t           wr,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr
);
    logic [WR_LEN-1:0] buf_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              par_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q <= '0;
            cnt_q <= '0;
        end else if (sel) begin
            if (capture) begin
                buf_q <= '0;
                cnt_q <= '0;
            end else if (shift) begin
                if (cnt_q < CNT_W'(WR_LEN))
                    buf_q[cnt_q] <= tdi;
                if (cnt_q != '1)
                    cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Bits beyond the frame length are held at zero, so the whole buffer gives the parity.
    assign par_ok   = ones_odd(buf_q);
    assign wr.data  = buf_q[WORD_W-1:0];
    assign wr.addr  = buf_q[WORD_W +: ADDR_W];
    assign rd_addr  = buf_q[ADDR_W-1:0];
    assign wr_valid = sel && update && par_ok && (cnt_q == CNT_W'(WR_LEN)) && buf_q[WR_LEN-2];
    assign rd_valid = sel && update && par_ok && (cnt_q == CNT_W'(RD_LEN)) && !buf_q[RD_LEN-2];
endmodule

// File: rtl/jrs_regfile.sv
module jrs_regfile
    import jrs_pkg::*;
#(
    parameter int N_JOB = NUM_JOB
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_valid,
    input  wr_req_t                 wr,
    input  logic [ADDR_W-1:0]       rd_addr,
    input  logic                    res_empty,
    input  logic [WORD_W-1:0]       res_data,
    output logic [WORD_W-1:0]       rd_data,
    output logic [N_JOB*WORD_W-1:0] job_words,
    output logic [WORD_W-1:0]       clk_cfg,
    output logic                    job_start
);
    logic [WORD_W-1:0] job_q [N_JOB];
    logic [WORD_W-1:0] cfg_q;
    logic              start_req_q, start_q;

    for (genvar g = 0; g < N_JOB; g++) begin : g_job
        always_ff @(posedge clk) begin
            if (rst)
                job_q[g] <= '0;
            else if (wr_valid && wr.addr == ADDR_W'(g + 1))
                job_q[g] <= wr.data;
        end
        assign job_words[g*WORD_W +: WORD_W] = job_q[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q       <= '0;
            start_req_q <= 1'b0;
            start_q     <= 1'b0;
        end else begin
            if (wr_valid && wr.addr == ADDR_CLKCFG)
                cfg_q <= wr.data;
            start_req_q <= wr_valid && wr.addr == ADDR_LAUNCH;
            start_q     <= start_req_q;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N_JOB; i++)
            if (rd_addr == ADDR_W'(i + 1))
                rd_data = job_q[i];
        if (rd_addr == ADDR_CLKCFG)
            rd_data = cfg_q;
        if (rd_addr == ADDR_RESULT)
            rd_data = res_empty ? '1 : res_data;
    end

    assign clk_cfg   = cfg_q;
    assign job_start = start_q;

    // R6
    a_r6_start_source: assert property (@(posedge clk) disable iff (rst)
        job_start |-> $past(wr_valid && wr.addr == ADDR_LAUNCH, 2));
    // R2
    a_r2_cfg_written: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr.addr == ADDR_CLKCFG) |=> clk_cfg == $past(wr.data));
    // R8
    a_r8_unmapped_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && (wr.addr == 4'd0 || wr.addr == 4'd12 || wr.addr == 4'd14 || wr.addr == 4'd15))
        |=> ($stable(clk_cfg) && $stable(job_words)));
endmodule

// File: rtl/jrs_readout.sv
module jrs_readout
    import jrs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              capture,
    input  logic              shift,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr_in,
    input  logic [WORD_W-1:0] rd_data,
    input  logic              res_empty,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              res_pop,
    output logic              tdo
);
    logic              pend_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            addr_q <= '0;
            out_q  <= '0;
        end else if (rd_valid) begin
            pend_q <= 1'b1;
            addr_q <= rd_addr_in;
        end else if (sel && capture) begin
            out_q  <= pend_q ? rd_data : '0;
            pend_q <= 1'b0;
        end else if (sel && shift) begin
            out_q <= out_q >> 1;
        end
    end

    assign rd_addr = addr_q;
    assign res_pop = sel && capture && pend_q && (addr_q == ADDR_RESULT) && !res_empty;
    assign tdo     = out_q[0];

    // R7
    a_r7_single_pop: assert property (@(posedge clk) disable iff (rst)
        res_pop |=> !res_pop);
    // R3
    a_r3_serial_order: assert property (@(posedge clk) disable iff (rst)
        (sel && shift && !capture && !rd_valid) |=> tdo == $past(out_q[1]));
endmodule

// File: rtl/jrs_top.sv
module jrs_top
    import jrs_pkg::*;
#(
    parameter int N_JOB = NUM_JOB
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sel,
    input  logic                    capture,
    input  logic                    shift,
    input  logic                    update,
    input  logic                    tdi,
    output logic                    tdo,
    input  logic                    res_empty,
    input  logic [WORD_W-1:0]       res_data,
    output logic                    res_pop,
    output logic [N_JOB*WORD_W-1:0] job_words,
    output logic [WORD_W-1:0]       clk_cfg,
    output logic                    job_start
);
    wr_req_t           wr;
    logic              wr_valid, rd_valid;
    logic [ADDR_W-1:0] rq_addr, pend_addr;
    logic [WORD_W-1:0] rd_data;

    jrs_frame_rx u_rx (
        .clk(clk), .rst(rst), .sel(sel), .capture(capture), .shift(shift),
        .update(update), .tdi(tdi), .wr_valid(wr_valid), .wr(wr),
        .rd_valid(rd_valid), .rd_addr(rq_addr)
    );

    jrs_regfile #(.N_JOB(N_JOB)) u_rf (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr(wr), .rd_addr(pend_addr),
        .res_empty(res_empty), .res_data(res_data), .rd_data(rd_data),
        .job_words(job_words), .clk_cfg(clk_cfg), .job_start(job_start)
    );

    jrs_readout u_ro (
        .clk(clk), .rst(rst), .sel(sel), .capture(capture), .shift(shift),
        .rd_valid(rd_valid), .rd_addr_in(rq_addr), .rd_data(rd_data),
        .res_empty(res_empty), .rd_addr(pend_addr), .res_pop(res_pop), .tdo(tdo)
    );

    // R9
    a_r9_deselected_quiet: assert property (@(posedge clk) disable iff (rst)
        !sel |=> ($stable(job_words) && $stable(clk_cfg)));
endmodule

// File: tb/tb_jrs_top.sv
module tb_jrs_top;
    localparam int CLK_P = 10;
    localparam int NJ    = 11;

    logic clk = 1'b0;
    logic rst, sel, capture, shift, update, tdi;
    logic tdo, res_pop, job_start;
    logic res_empty;
    logic [31:0] res_data, clk_cfg;
    logic [NJ*32-1:0] job_words;

    logic [31:0] fmem [8];
    int fcnt = 0, fhead = 0, pops = 0;
    int vectors = 0, miscompares = 0;
    logic [31:0] refr [16];

    always #(CLK_P/2) clk = ~clk;

    assign res_empty = (fhead >= fcnt);
    assign res_data  = (fhead < fcnt) ? fmem[fhead[2:0]] : 32'h5A5A_0F0F;

    jrs_top dut (
        .clk(clk), .rst(rst), .sel(sel), .capture(capture), .shift(shift),
        .update(update), .tdi(tdi), .tdo(tdo), .res_empty(res_empty),
        .res_data(res_data), .res_pop(res_pop), .job_words(job_words),
        .clk_cfg(clk_cfg), .job_start(job_start)
    );

    initial begin
        #(CLK_P * 150000);
        miscompares++;
        $display("FAIL watchdog: run hung, actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [63:0] mk_wr(input logic [3:0] a, input logic [31:0] d,
                                          input bit wflag, input bit bad);
        logic [63:0] f = '0;
        f[31:0]  = d;
        f[35:32] = a;
        f[36]    = wflag;
        f[37]    = ~^f[36:0];
        if (bad) f[37] = ~f[37];
        return f;
    endfunction

    function automatic logic [63:0] mk_rd(input logic [3:0] a, input bit rflag, input bit bad);
        logic [63:0] f = '0;
        f[3:0] = a;
        f[4]   = rflag;
        f[5]   = ~^f[4:0];
        if (bad) f[5] = ~f[5];
        return f;
    endfunction

    function automatic logic [31:0] exp_read(input logic [3:0] a);
        if ((a >= 1 && a <= 11) || a == 13) return refr[a];
        if (a == 14) return (fhead < fcnt) ? fmem[fhead[2:0]] : 32'hFFFF_FFFF;
        return 32'h0;
    endfunction

    task automatic scan(input logic [63:0] bits, input int len, input bit s,
                        output logic [63:0] got, output bit popped);
        got = '0;
        sel = s; capture = 1'b1;
        #1 popped = res_pop;
        tick();
        capture = 1'b0;
        if (popped) begin fhead++; pops++; end
        for (int i = 0; i < len; i++) begin
            tdi = bits[i]; shift = 1'b1;
            #1 if (i < 64) got[i] = tdo;
            tick();
        end
        shift = 1'b0; tdi = 1'b0; update = 1'b1;
        tick();
        update = 1'b0; sel = 1'b0;
    endtask

    task automatic check_ports(input string req);
        for (int k = 0; k < NJ; k++)
            chk(req, job_words[k*32 +: 32], refr[k+1]);
        chk(req, clk_cfg, refr[13]);
    endtask

    task automatic do_write(input logic [3:0] a, input logic [31:0] d, input bit bad,
                            input int len, input bit wflag, input bit s);
        logic [63:0] g;
        bit p;
        logic l1, l2, l3;
        bit ok;
        scan(mk_wr(a, d, wflag, bad), len, s, g, p);
        l1 = job_start; tick(); l2 = job_start; tick(); l3 = job_start;
        ok = !bad && len == 38 && wflag && s;
        if (ok && ((a >= 1 && a <= 11) || a == 13)) refr[a] = d;
        // R6: start pulse only for a valid write of address 11
        chk("R6 start pulse", {29'd0, l1, l2, l3}, {30'd0, (ok && a == 4'd11), 1'b0});
    endtask

    task automatic do_read(input logic [3:0] a, input bit bad, input bit rflag,
                           output logic [31:0] val, output bit popped);
        logic [63:0] g;
        bit p;
        scan(mk_rd(a, rflag, bad), 6, 1'b1, g, p);
        scan(64'd0, 32, 1'b1, g, popped);
        val = g[31:0];
    endtask

    initial begin
        logic [31:0] v;
        bit p;
        int  pop0;
        void'($urandom(32'd1234));
        for (int i = 0; i < 16; i++) refr[i] = '0;
        rst = 1'b1; sel = 1'b0; capture = 1'b0; shift = 1'b0; update = 1'b0; tdi = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check_ports("R1 reset");
        chk("R1 reset start/tdo", {30'd0, job_start, tdo}, 32'd0);

        // R2 directed writes, then read back each (R3)
        for (int a = 1; a <= 13; a++)
            if (a != 12) do_write(4'(a), 32'h1000_0001 * a ^ 32'hA5C3_0000, 1'b0, 38, 1'b1, 1'b1);
        check_ports("R2 write");
        for (int a = 0; a < 16; a++) begin
            logic [31:0] e;
            e = exp_read(4'(a));
            do_read(4'(a), 1'b0, 1'b0, v, p);
            chk($sformatf("R3/R8 read addr %0d", a), v, e);
        end

        // R4 parity errors
        do_write(4'd5, 32'hDEAD_0005, 1'b1, 38, 1'b1, 1'b1);
        check_ports("R4 bad parity write");
        do_read(4'd5, 1'b1, 1'b0, v, p);
        chk("R4/R10 bad parity read gives zero", v, 32'h0);

        // R5 length and flag errors
        do_write(4'd6, 32'h1111_2222, 1'b0, 37, 1'b1, 1'b1);
        do_write(4'd6, 32'h3333_4444, 1'b0, 39, 1'b1, 1'b1);
        do_write(4'd6, 32'h5555_6666, 1'b0, 38, 1'b0, 1'b1);
        check_ports("R5 length/flag write");
        do_read(4'd6, 1'b0, 1'b1, v, p);
        chk("R5 read with write flag gives zero", v, 32'h0);

        // R10 a pending request serves one scan only
        do_read(4'd3, 1'b0, 1'b0, v, p);
        chk("R10 first scan", v, refr[3]);
        begin
            logic [63:0] g;
            scan(64'd0, 32, 1'b1, g, p);
            chk("R10 second scan zero", g[31:0], 32'h0);
        end

        // R7 result queue
        fmem[0] = 32'h0000_00A1; fmem[1] = 32'hFFFF_FFFE; fmem[2] = 32'h1234_5678; fcnt = 3; fhead = 0;
        pop0 = pops;
        for (int i = 0; i < 4; i++) begin
            logic [31:0] e;
            e = exp_read(4'd14);
            do_read(4'd14, 1'b0, 1'b0, v, p);
            chk("R7 result read", v, e);
            chk("R7 pop flag", {31'd0, p}, {31'd0, (i < 3)});
        end
        chk("R7 pop count", pops - pop0, 32'd3);

        // R8 unmapped writes ignored
        do_write(4'd0, 32'hFFFF_FFFF, 1'b0, 38, 1'b1, 1'b1);
        do_write(4'd12, 32'hFFFF_FFFF, 1'b0, 38, 1'b1, 1'b1);
        do_write(4'd14, 32'hFFFF_FFFF, 1'b0, 38, 1'b1, 1'b1);
        do_write(4'd15, 32'hFFFF_FFFF, 1'b0, 38, 1'b1, 1'b1);
        check_ports("R8 unmapped write");
        do_read(4'd12, 1'b0, 1'b0, v, p);
        chk("R8 addr 12 zero", v, 32'h0);

        // R9 deselected scan
        do_write(4'd11, 32'h7777_7777, 1'b0, 38, 1'b1, 1'b0);
        check_ports("R9 deselected");

        // Random mix
        for (int it = 0; it < 250; it++) begin
            logic [3:0]  a;
            logic [31:0] d;
            bit bad;
            a   = 4'($urandom_range(0, 15));
            d   = $urandom;
            bad = ($urandom_range(0, 3) == 0);
            do_write(a, d, bad, 38, 1'b1, 1'b1);
            check_ports(bad ? "R4 random bad parity" : "R2 random write");
            if (it % 5 == 0) begin
                logic [3:0]  ra;
                logic [31:0] e;
                ra = 4'($urandom_range(0, 15));
                e  = exp_read(ra);
                do_read(ra, 1'b0, 1'b0, v, p);
                chk("R3 random read", v, e);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule